// File: doc/BRIEF.md
# Serial Programming Target with Staged Page Buffer

This block is the target side of a four-byte serial programming link. A host clocks instruction bytes in on `mosi`, most significant bit first, on rising edges of `sck`. The target answers on `miso`, changing its output only after falling edges of `sck`, so the host can sample it on the next rising edge. The target does nothing until it has received an enable instruction. After that it accepts page loads, page commits, reads and a status poll.

Two memories are modelled in registers: a word-wide program store and a byte-wide data store. Both are organised as pages of `2**SLOT_BITS` locations. Load instructions fill a staging buffer, one location at a time. A commit instruction copies the buffer into one page of the chosen store and then starts a busy timer. For the program store, every word of the page is written. For the data store, only the bytes loaded since the last commit are written. While the timer runs, the only instructions that take effect are the enable instruction and the status poll.

Top module: `spt_target`

## Requirements
- R1: A frame is four bytes shifted in MSB first, with `mosi` captured on rising `sck` edges. `miso` changes only in response to a falling `sck` edge and holds steady while `sck` stays high. An instruction takes effect only when the 32nd bit has been captured.
- R2: During the first byte of every frame `miso` returns 0x00. During the second byte it returns the first received byte, and during the third byte it returns the second received byte. For the enable frame AC 53 xx xx, this means 0x53 comes back while the third byte is shifted in.
- R3: After reset, every frame other than enable (AC 53 xx xx) is ignored until an enable frame completes. An ignored frame makes no change to any buffer or store, and its fourth output byte echoes its third received byte.
- R4: Program-buffer loads use 40 00 aa dd for the low byte and 48 00 aa dd for the high byte of slot aa modulo `2**SLOT_BITS`. A high-byte load is discarded unless the low byte of that slot has been loaded since the last program commit.
- R5: The program commit 4C hh ll 00 writes page ({hh[4:0],ll} >> 6) modulo `2**PAGE_BITS`, and it writes every slot of that page. A slot that was not loaded is written as 0xFF/0xFF. The commit then resets the program buffer to 0xFF and clears its valid bits. Other pages are unchanged.
- R6: Program reads use 20 hh ll xx for the low byte and 28 hh ll xx for the high byte of word address {hh[4:0],ll}. The selected byte is returned during the fourth byte.
- R7: Data-buffer loads use C1 00 aa dd. The data commit C2 hh ll 00 writes, in the addressed page, only the bytes loaded since the previous data commit. All other bytes keep their old contents, and all data valid bits are cleared by the commit.
- R8: The data read A0 hh ll xx returns the byte at address {hh[4:0],ll} during the fourth byte. The location used is page bits [6 +: PAGE_BITS] and slot bits [SLOT_BITS-1:0].
- R9: After either commit the target is busy for `WRITE_CYCLES` clock cycles. The poll F0 00 00 xx returns 0x01 in its fourth byte while busy and 0x00 otherwise.
- R10: While busy, loads, commits and reads are ignored: there is no change to the buffers or stores, and a read's fourth byte echoes its third received byte.
- R11: While `rst` is high, the bit and byte position, the enable flag and the busy timer are cleared, `miso` is driven 0, and both stores and the buffers are set to 0xFF. A partly shifted frame is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk  | input  | 1 | Block clock; `sck` and `mosi` are sampled on its rising edge |
| rst  | input  | 1 | Synchronous reset, active high |
| sck  | input  | 1 | Serial clock from the host, slower than `clk` |
| mosi | input  | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
The bench targets the cases that a plausible implementation most easily gets wrong:
- **Echo position.** A target that echoes one byte late would return 0xAC instead of 0x53 during the third byte of the enable frame.
- **High byte before low byte.** A target that does not enforce the ordering would store a high byte loaded with no preceding low byte.
- **Buffer clearing after commit.** A target that keeps the staging buffer after a commit would copy stale words into the next page.
- **Unloaded data bytes.** A data commit that writes the whole page would overwrite them with 0xFF.
- **Busy window.** Loads and reads issued while busy must leave no trace, and the poll must read 1 inside the window and 0 after it.
- **Reset mid-frame.** After a reset in the middle of a frame, a misaligned shifter would corrupt the next enable echo.

// File: rtl/spt_pkg.sv
package spt_pkg;

  localparam logic [7:0] OP_ENABLE   = 8'hAC;
  localparam logic [7:0] ENABLE_KEY  = 8'h53;
  localparam logic [7:0] OP_LD_FL_LO = 8'h40;
  localparam logic [7:0] OP_LD_FL_HI = 8'h48;
  localparam logic [7:0] OP_WR_FL    = 8'h4C;
  localparam logic [7:0] OP_RD_FL_LO = 8'h20;
  localparam logic [7:0] OP_RD_FL_HI = 8'h28;
  localparam logic [7:0] OP_LD_EE    = 8'hC1;
  localparam logic [7:0] OP_WR_EE    = 8'hC2;
  localparam logic [7:0] OP_RD_EE    = 8'hA0;
  localparam logic [7:0] OP_POLL     = 8'hF0;

  typedef enum logic [3:0] {
    CMD_NONE, CMD_ENABLE, CMD_LD_FL_LO, CMD_LD_FL_HI, CMD_WR_FL,
    CMD_RD_FL_LO, CMD_RD_FL_HI, CMD_LD_EE, CMD_WR_EE, CMD_RD_EE, CMD_POLL
  } cmd_e;

  // Classify an instruction from its first two bytes.
  function automatic cmd_e decode_cmd(input logic [7:0] op, input logic [7:0] arg);
    case (op)
      OP_ENABLE:   return (arg == ENABLE_KEY) ? CMD_ENABLE : CMD_NONE;
      OP_LD_FL_LO: return CMD_LD_FL_LO;
      OP_LD_FL_HI: return CMD_LD_FL_HI;
      OP_WR_FL:    return CMD_WR_FL;
      OP_RD_FL_LO: return CMD_RD_FL_LO;
      OP_RD_FL_HI: return CMD_RD_FL_HI;
      OP_LD_EE:    return CMD_LD_EE;
      OP_WR_EE:    return CMD_WR_EE;
      OP_RD_EE:    return CMD_RD_EE;
      OP_POLL:     return CMD_POLL;
      default:     return CMD_NONE;
    endcase
  endfunction

  // Instructions whose fourth output byte carries data.
  function automatic logic answers(input cmd_e c);
    return (c == CMD_RD_FL_LO) || (c == CMD_RD_FL_HI) ||
           (c == CMD_RD_EE) || (c == CMD_POLL);
  endfunction

  // 13-bit word address formed from the second and third bytes.
  function automatic logic [12:0] word_addr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi[4:0], lo};
  endfunction

endpackage

// File: rtl/spt_shift.sv
module spt_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck,
  input  logic       mosi,
  input  logic [7:0] tx_next,
  output logic       miso,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic [1:0] rx_idx
);
  logic       sck_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh;
  logic [7:0] tx_hold;
  logic       tx_pend;
  logic [1:0] idx_q;

  wire sck_rise = sck & ~sck_q;
  wire sck_fall = ~sck & sck_q;

  assign byte_done = sck_rise && (bit_cnt == 3'd7);
  assign rx_byte   = {rx_sh, mosi};
  assign rx_idx    = idx_q;
  assign miso      = tx_sh[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q   <= 1'b0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      tx_hold <= '0;
      tx_pend <= 1'b0;
      idx_q   <= '0;
    end else begin
      sck_q <= sck;
      if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) idx_q <= idx_q + 2'd1;
      end
      if (byte_done) begin
        tx_hold <= tx_next;
        tx_pend <= 1'b1;
      end
      if (sck_fall) begin
        if (tx_pend) begin
          tx_sh   <= tx_hold;
          tx_pend <= 1'b0;
        end else begin
          tx_sh <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R1: output only moves on a falling serial clock edge
  assert_miso_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (sck && sck_q) |=> $stable(miso));

  // R1: the byte position wraps after the fourth byte
  assert_frame_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (byte_done && rx_idx == 2'd3) |=> (rx_idx == 2'd0));

endmodule

// File: rtl/spt_pagebuf.sv
module spt_pagebuf #(
  parameter int SLOT_BITS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_lo,
  input  logic                     ld_hi,
  input  logic                     ld_ee,
  input  logic                     clr_fl,
  input  logic                     clr_ee,
  input  logic [SLOT_BITS-1:0]     slot,
  input  logic [7:0]               din,
  output logic [(1<<SLOT_BITS)-1:0][7:0] fl_lo,
  output logic [(1<<SLOT_BITS)-1:0][7:0] fl_hi,
  output logic [(1<<SLOT_BITS)-1:0][7:0] ee_data,
  output logic [(1<<SLOT_BITS)-1:0]      ee_vld
);
  localparam int SLOTS = 1 << SLOT_BITS;

  logic [SLOTS-1:0] lo_vld;
  wire hi_ok = ld_hi && lo_vld[slot];

  always_ff @(posedge clk) begin
    if (rst || clr_fl) begin
      fl_lo  <= '1;
      fl_hi  <= '1;
      lo_vld <= '0;
    end else begin
      if (ld_lo) begin
        fl_lo[slot]  <= din;
        lo_vld[slot] <= 1'b1;
      end
      if (hi_ok) fl_hi[slot] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_ee) begin
      ee_data <= '1;
      ee_vld  <= '0;
    end else if (ld_ee) begin
      ee_data[slot] <= din;
      ee_vld[slot]  <= 1'b1;
    end
  end

  // R4: a high byte with no earlier low byte in the slot leaves the buffer alone
  assert_hi_needs_lo_R4: assert property (@(posedge clk) disable iff (rst)
    (ld_hi && !clr_fl && !lo_vld[slot]) |=> $stable(fl_hi));

  // R5: a program commit empties the program buffer
  assert_fl_cleared_R5: assert property (@(posedge clk) disable iff (rst)
    clr_fl |=> ((&fl_lo) && (&fl_hi)));

  // R7: a data commit drops every loaded mark
  assert_ee_marks_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    clr_ee |=> (ee_vld == '0));

endmodule

// File: rtl/spt_array.sv
module spt_array #(
  parameter int SLOT_BITS = 3,
  parameter int PAGE_BITS = 2
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 wr_fl,
  input  logic                                 wr_ee,
  input  logic [PAGE_BITS-1:0]                 wr_page,
  input  logic [(1<<SLOT_BITS)-1:0][7:0]       buf_lo,
  input  logic [(1<<SLOT_BITS)-1:0][7:0]       buf_hi,
  input  logic [(1<<SLOT_BITS)-1:0][7:0]       buf_ee,
  input  logic [(1<<SLOT_BITS)-1:0]            buf_ee_vld,
  input  logic [SLOT_BITS+PAGE_BITS-1:0]       rd_loc,
  output logic [7:0]                           rd_lo,
  output logic [7:0]                           rd_hi,
  output logic [7:0]                           rd_ee
);
  localparam int SLOTS = 1 << SLOT_BITS;
  localparam int PAGES = 1 << PAGE_BITS;
  localparam int DEPTH = SLOTS * PAGES;

  logic [DEPTH-1:0][7:0] mem_lo;
  logic [DEPTH-1:0][7:0] mem_hi;
  logic [DEPTH-1:0][7:0] mem_ee;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_lo <= '1;
      mem_hi <= '1;
      mem_ee <= '1;
    end else begin
      for (int p = 0; p < PAGES; p++) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (wr_fl && wr_page == PAGE_BITS'(p)) begin
            mem_lo[p*SLOTS+s] <= buf_lo[s];
            mem_hi[p*SLOTS+s] <= buf_hi[s];
          end
          if (wr_ee && wr_page == PAGE_BITS'(p) && buf_ee_vld[s])
            mem_ee[p*SLOTS+s] <= buf_ee[s];
        end
      end
    end
  end

  assign rd_lo = mem_lo[rd_loc];
  assign rd_hi = mem_hi[rd_loc];
  assign rd_ee = mem_ee[rd_loc];

  // R7: a data commit with nothing loaded changes no byte
  assert_ee_unloaded_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_ee && !(|buf_ee_vld)) |=> $stable(mem_ee));

  // R5: the program store only moves on a program commit
  assert_fl_only_on_commit_R5: assert property (@(posedge clk) disable iff (rst)
    !wr_fl |=> ($stable(mem_lo) && $stable(mem_hi)));

endmodule

// File: rtl/spt_busy.sv
module spt_busy #(
  parameter int WRITE_CYCLES = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [CW-1:0] remain;

  assign busy = (remain != '0);

  always_ff @(posedge clk) begin
    if (rst)        remain <= '0;
    else if (start) remain <= CW'(WRITE_CYCLES);
    else if (busy)  remain <= remain - 1'b1;
  end

  // R9: a commit raises busy on the next cycle
  assert_busy_on_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);

  // R9: busy drops once the last cycle of the window is spent
  assert_busy_ends_R9: assert property (@(posedge clk) disable iff (rst)
    (remain == CW'(1) && !start) |=> !busy);

endmodule

// File: rtl/spt_target.sv
module spt_target #(
  parameter int SLOT_BITS    = 3,
  parameter int PAGE_BITS    = 2,
  parameter int WRITE_CYCLES = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic mosi,
  output logic miso
);
  import spt_pkg::*;

  localparam int SLOTS    = 1 << SLOT_BITS;
  localparam int LOC_BITS = SLOT_BITS + PAGE_BITS;

  // Location in a store: page bits sit above the 6-bit in-page field.
  function automatic logic [LOC_BITS-1:0] loc_of(input logic [7:0] hi, input logic [7:0] lo);
    logic [12:0] a;
    a = word_addr(hi, lo);
    return {a[6 +: PAGE_BITS], a[SLOT_BITS-1:0]};
  endfunction

  logic       byte_done;
  logic [7:0] rx_byte;
  logic [1:0] rx_idx;
  logic [7:0] tx_next;

  logic [7:0] b0_q, b1_q, b2_q;
  logic       enabled_q;
  logic       busy;

  logic [SLOTS-1:0][7:0] buf_lo, buf_hi, buf_ee;
  logic [SLOTS-1:0]      buf_ee_vld;
  logic [7:0]            rd_lo, rd_hi, rd_ee;

  spt_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .sck       (sck),
    .mosi      (mosi),
    .tx_next   (tx_next),
    .miso      (miso),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .rx_idx    (rx_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      b0_q <= '0;
      b1_q <= '0;
      b2_q <= '0;
    end else if (byte_done) begin
      case (rx_idx)
        2'd0:    b0_q <= rx_byte;
        2'd1:    b1_q <= rx_byte;
        2'd2:    b2_q <= rx_byte;
        default: ;
      endcase
    end
  end

  // Decode and acceptance, named for the assertions.
  cmd_e cmd;
  logic allowed;
  logic [7:0] addr_lo;
  logic [LOC_BITS-1:0] loc;

  assign cmd     = decode_cmd(b0_q, b1_q);
  assign allowed = (cmd == CMD_ENABLE) || (enabled_q && (!busy || cmd == CMD_POLL));
  assign addr_lo = (rx_idx == 2'd2) ? rx_byte : b2_q;
  assign loc     = loc_of(b1_q, addr_lo);

  wire frame_done = byte_done && (rx_idx == 2'd3);
  wire exec       = frame_done && allowed;
  wire ld_lo      = exec && (cmd == CMD_LD_FL_LO);
  wire ld_hi      = exec && (cmd == CMD_LD_FL_HI);
  wire ld_ee      = exec && (cmd == CMD_LD_EE);
  wire wr_fl      = exec && (cmd == CMD_WR_FL);
  wire wr_ee      = exec && (cmd == CMD_WR_EE);
  wire commit     = wr_fl || wr_ee;
  wire any_load   = ld_lo || ld_hi || ld_ee;

  always_ff @(posedge clk) begin
    if (rst)                             enabled_q <= 1'b0;
    else if (exec && cmd == CMD_ENABLE)  enabled_q <= 1'b1;
  end

  // Byte offered for the next slot of the frame.
  logic [7:0] answer;
  always_comb begin
    case (cmd)
      CMD_RD_FL_LO: answer = rd_lo;
      CMD_RD_FL_HI: answer = rd_hi;
      CMD_RD_EE:    answer = rd_ee;
      CMD_POLL:     answer = {7'd0, busy};
      default:      answer = rx_byte;
    endcase
    case (rx_idx)
      2'd2:    tx_next = (allowed && answers(cmd)) ? answer : rx_byte;
      2'd3:    tx_next = 8'h00;
      default: tx_next = rx_byte;
    endcase
  end

  spt_pagebuf #(.SLOT_BITS(SLOT_BITS)) u_pagebuf (
    .clk     (clk),
    .rst     (rst),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .ld_ee   (ld_ee),
    .clr_fl  (wr_fl),
    .clr_ee  (wr_ee),
    .slot    (loc[SLOT_BITS-1:0]),
    .din     (rx_byte),
    .fl_lo   (buf_lo),
    .fl_hi   (buf_hi),
    .ee_data (buf_ee),
    .ee_vld  (buf_ee_vld)
  );

  spt_array #(.SLOT_BITS(SLOT_BITS), .PAGE_BITS(PAGE_BITS)) u_array (
    .clk        (clk),
    .rst        (rst),
    .wr_fl      (wr_fl),
    .wr_ee      (wr_ee),
    .wr_page    (loc[LOC_BITS-1:SLOT_BITS]),
    .buf_lo     (buf_lo),
    .buf_hi     (buf_hi),
    .buf_ee     (buf_ee),
    .buf_ee_vld (buf_ee_vld),
    .rd_loc     (loc),
    .rd_lo      (rd_lo),
    .rd_hi      (rd_hi),
    .rd_ee      (rd_ee)
  );

  spt_busy #(.WRITE_CYCLES(WRITE_CYCLES)) u_busy (
    .clk   (clk),
    .rst   (rst),
    .start (commit),
    .busy  (busy)
  );

  // R3: nothing is loaded or committed before the enable frame
  assert_enable_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !enabled_q |-> !(any_load || commit));

  // R10: the busy window blocks loads and commits
  assert_busy_gate_R10: assert property (@(posedge clk) disable iff (rst)
    busy |-> !(any_load || commit));

endmodule

// File: tb/spt_target_bench.sv
module spt_target_bench;
  localparam int SLOT_BITS    = 3;
  localparam int PAGE_BITS    = 2;
  localparam int WRITE_CYCLES = 800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0;
  logic mosi = 1'b0;
  wire  miso;

  int checks = 0;
  int errors = 0;
  int hold_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spt_target #(
    .SLOT_BITS(SLOT_BITS), .PAGE_BITS(PAGE_BITS), .WRITE_CYCLES(WRITE_CYCLES)
  ) u_spt_target (
    .clk(clk), .rst(rst), .sck(sck), .mosi(mosi), .miso(miso)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One bit: host samples miso just before raising sck.
  task automatic bit_cycle(input logic b, output logic m);
    logic pre;
    @(negedge clk) mosi = b;
    repeat (3) @(negedge clk);
    pre = miso;
    m = pre;
    sck = 1'b1;
    repeat (2) @(negedge clk);
    if (miso !== pre) hold_bad++;
    repeat (2) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [31:0] w, output logic [31:0] r);
    for (int i = 31; i >= 0; i--) begin
      logic m;
      bit_cycle(w[i], m);
      r[i] = m;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w);
    logic [31:0] r;
    frame(w, r);
  endtask

  task automatic wait_idle();
    repeat (WRITE_CYCLES + 20) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R11", "miso during reset", miso, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk("R11", "miso after reset", miso, 1'b0);
  endtask

  task automatic t_pre_enable();
    logic [31:0] r;
    send(32'h40_00_01_5A);
    frame(32'h20_00_01_00, r);
    chk("R3", "read before enable echoes", r[7:0], 8'h01);
    send(32'h4C_00_00_00);
  endtask

  task automatic t_enable();
    logic [31:0] r;
    frame(32'hAC_53_00_00, r);
    chk("R2", "first byte out", r[31:24], 8'h00);
    chk("R2", "second byte echoes opcode", r[23:16], 8'hAC);
    chk("R2", "key echoed in third byte", r[15:8], 8'h53);
    frame(32'h20_00_01_00, r);
    chk("R3", "pre-enable load and commit ignored", r[7:0], 8'hFF);
    chk("R11", "store erased after reset", r[7:0], 8'hFF);
  endtask

  task automatic t_flash();
    logic [31:0] r;
    send(32'h40_00_02_34);
    send(32'h48_00_02_12);
    send(32'h48_00_05_77);
    send(32'h4C_00_40_00);
    wait_idle();
    frame(32'h20_00_42_00, r); chk("R6", "low byte page1 slot2", r[7:0], 8'h34);
    frame(32'h28_00_42_00, r); chk("R6", "high byte page1 slot2", r[7:0], 8'h12);
    frame(32'h28_00_45_00, r); chk("R4", "high without low dropped", r[7:0], 8'hFF);
    frame(32'h20_00_43_00, r); chk("R5", "unloaded slot written 0xFF", r[7:0], 8'hFF);
    frame(32'h20_00_02_00, r); chk("R5", "other page untouched", r[7:0], 8'hFF);
    send(32'h4C_00_80_00);
    wait_idle();
    frame(32'h20_00_82_00, r); chk("R5", "buffer cleared after commit", r[7:0], 8'hFF);
    send(32'h48_00_02_66);
    send(32'h4C_00_C0_00);
    wait_idle();
    frame(32'h28_00_C2_00, r); chk("R4", "low mark cleared by commit", r[7:0], 8'hFF);
    frame(32'h28_00_42_00, r); chk("R5", "earlier page kept", r[7:0], 8'h12);
  endtask

  task automatic t_eeprom();
    logic [31:0] r;
    send(32'hC1_00_00_A1);
    send(32'hC1_00_03_B3);
    send(32'hC2_00_00_00);
    wait_idle();
    frame(32'hA0_00_00_00, r); chk("R8", "data slot0", r[7:0], 8'hA1);
    frame(32'hA0_00_03_00, r); chk("R8", "data slot3", r[7:0], 8'hB3);
    frame(32'hA0_00_01_00, r); chk("R7", "unloaded slot1 kept", r[7:0], 8'hFF);
    send(32'hC1_00_01_C1);
    send(32'hC2_00_00_00);
    wait_idle();
    frame(32'hA0_00_00_00, r); chk("R7", "slot0 kept on second commit", r[7:0], 8'hA1);
    frame(32'hA0_00_01_00, r); chk("R7", "slot1 written", r[7:0], 8'hC1);
    frame(32'hA0_00_03_00, r); chk("R7", "slot3 kept", r[7:0], 8'hB3);
    frame(32'hA0_00_41_00, r); chk("R8", "other page untouched", r[7:0], 8'hFF);
  endtask

  task automatic t_busy();
    logic [31:0] r;
    send(32'hC1_00_05_55);
    send(32'hC2_00_00_00);
    frame(32'hF0_00_00_00, r); chk("R9", "poll while busy", r[7:0], 8'h01);
    send(32'hC1_00_02_22);
    frame(32'hA0_00_05_00, r); chk("R10", "read while busy echoes", r[7:0], 8'h05);
    frame(32'hF0_00_00_00, r); chk("R9", "poll after window", r[7:0], 8'h00);
    send(32'hC2_00_00_00);
    wait_idle();
    frame(32'hA0_00_02_00, r); chk("R10", "load while busy dropped", r[7:0], 8'hFF);
    frame(32'hA0_00_05_00, r); chk("R7", "committed byte present", r[7:0], 8'h55);
  endtask

  task automatic t_midframe_reset();
    logic [31:0] r;
    for (int i = 0; i < 12; i++) begin
      logic m;
      bit_cycle(i[0], m);
    end
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "miso cleared by reset", miso, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    send(32'h40_00_00_99);
    send(32'h4C_00_00_00);
    frame(32'hAC_53_00_00, r);
    chk("R11", "frame realigned after reset", r[15:8], 8'h53);
    frame(32'h20_00_00_00, r); chk("R3", "enable cleared by reset", r[7:0], 8'hFF);
    frame(32'hA0_00_05_00, r); chk("R11", "data store erased", r[7:0], 8'hFF);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_pre_enable();
    t_enable();
    t_flash();
    t_eeprom();
    t_busy();
    t_midframe_reset();
    chk("R1", "miso steady while sck high", hold_bad, 0);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

endmodule